// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software run one management transaction at a time against an external Ethernet PHY over the two-wire MDC/MDIO bus. Software first loads a 16-bit data word for writes. It then writes a command word that carries the PHY address, the PHY register number and a start bit, either write or read. The engine serialises a standard 32-bit-preamble management frame. For a read it captures the 16 bits the PHY returns.

The start bit that launched the transaction reads back as 1 for as long as the frame is on the wire. It clears by itself when the frame ends, so software polls the command word until the bit drops. After a read bit drops, the read-data word holds the PHY's answer. The MDIO pin is split into separate input, output and output-enable signals, so the pad tri-state sits outside the block.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, and the command, read-data and write-data words at offsets 0x20, 0x24 and 0x28 all read as 0.
- R2: Register reads return their value one clock after the address is presented. Write-data (0x28) reads back what was written. The command word (0x20) reads back the PHY address of the last accepted command in bits 12:8, its register number in bits 4:0, the write busy flag in bit 14 and the read busy flag in bit 13. All other bits read 0.
- R3: Writing 0x20 with bit 14 set and the engine idle sends a write frame. The frame is 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register number, the turnaround 10 and the 16-bit write-data word, each field MSB first. MDIO is driven for all 64 bits.
- R4: Writing 0x20 with bit 13 set (bit 14 clear) and the engine idle sends a read frame with opcode 10. The output enable is low for the two turnaround bits and the 16 data bits (frame bits 46 to 63).
- R5: During a read, MDIO is sampled on each MDC rising edge of data bits 48 to 63, MSB first. The 16-bit result appears at 0x24 when the read busy flag clears.
- R6: The start bit that was accepted reads as 1 from the cycle after the command write until the frame ends. It clears at the same clock edge as the final MDC falling edge. At most one busy flag is ever set.
- R7: MDC has a period of 2*MDC_HALF system clocks while a frame runs, and it is low whenever the engine is idle.
- R8: A command write while either busy flag is set is ignored, including one in the very cycle the frame completes. Such a write starts no frame and leaves the stored PHY address unchanged.
- R9: A command with both bits 14 and 13 set runs as a write. A command with neither bit set starts nothing and changes no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
Two events can fall in the same cycle: the end of a frame, which clears the busy flag, and a new command write arriving on the bus. The bench counts 64 MDC rising edges and then exactly MDC_HALF clock cycles. That places a command write in the cycle whose edge lowers MDC for the last time. It then judges that no second frame appears on MDC, that the stored PHY address keeps its earlier value, and that a command issued a cycle later is accepted normally.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W      = 16;
  localparam int FIELD_W     = 5;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int TA_FIRST    = 46;
  localparam int BITN_W      = $clog2(FRAME_BITS);

  localparam logic [7:0] OFF_CMD = 8'h20;
  localparam logic [7:0] OFF_RDD = 8'h24;
  localparam logic [7:0] OFF_WRD = 8'h28;

  localparam int BIT_WR  = 14;
  localparam int BIT_RD  = 13;
  localparam int PHY_LSB = 8;
  localparam int REG_LSB = 0;

  localparam logic [1:0] SOF      = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_WRITE = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic wr, input logic [FIELD_W-1:0] phy, input logic [FIELD_W-1:0] rg,
    input logic [DATA_W-1:0] d);
    build_frame = {{PRE_BITS{1'b1}}, SOF, (wr ? OP_WRITE : OP_READ), phy, rg,
                   (wr ? TA_WRITE : 2'b11), (wr ? d : {DATA_W{1'b1}})};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int MDC_HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = $clog2(MDC_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;
  logic wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) !run |-> !mdc);
  // R7
  mdc_rise_chk: assert property (@(posedge clk) disable iff (rst) rise_stb |=> mdc);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_wr,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] rg,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               mdio_i,
  input  logic               rise_stb,
  input  logic               fall_stb,
  output logic               run,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rx
);
  localparam logic [BITN_W-1:0] BIT_END = BITN_W'(FRAME_BITS - 1);
  localparam logic [BITN_W-1:0] BIT_REL = BITN_W'(TA_FIRST - 1);

  logic [FRAME_BITS-1:0] sr;
  logic [BITN_W-1:0]     bitn;
  logic                  wr_q;

  assign done   = run && fall_stb && (bitn == BIT_END);
  assign mdio_o = sr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      sr      <= '0;
      bitn    <= '0;
      mdio_oe <= 1'b0;
      wr_q    <= 1'b0;
      rx      <= '0;
    end else if (start && !run) begin
      run     <= 1'b1;
      sr      <= build_frame(is_wr, phy, rg, wdata);
      bitn    <= '0;
      mdio_oe <= 1'b1;
      wr_q    <= is_wr;
    end else if (run) begin
      if (rise_stb) rx <= {rx[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        sr <= {sr[FRAME_BITS-2:0], 1'b0};
        if (done) begin
          run     <= 1'b0;
          mdio_oe <= 1'b0;
          bitn    <= '0;
        end else begin
          bitn <= bitn + 1'b1;
          if (!wr_q && bitn == BIT_REL) mdio_oe <= 1'b0;
        end
      end
    end
  end

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_q && bitn >= BITN_W'(TA_FIRST)) |-> !mdio_oe);
  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (run && wr_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               done,
  input  logic [DATA_W-1:0]  rx,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               start,
  output logic               start_wr,
  output logic               busy,
  output logic [DATA_W-1:0]  wd_q
);
  logic               wr_busy, rd_busy;
  logic [FIELD_W-1:0] phy_q, rg_q;
  logic [DATA_W-1:0]  rd_q;
  logic               cmd_sel, go_wr, go_rd;

  assign busy     = wr_busy | rd_busy;
  assign cmd_sel  = reg_wr && (reg_addr == ADDR_W'(OFF_CMD));
  assign go_wr    = cmd_sel && !busy && reg_wdata[BIT_WR];
  assign go_rd    = cmd_sel && !busy && !reg_wdata[BIT_WR] && reg_wdata[BIT_RD];
  assign start    = go_wr | go_rd;
  assign start_wr = go_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_busy   <= 1'b0;
      rd_busy   <= 1'b0;
      phy_q     <= '0;
      rg_q      <= '0;
      rd_q      <= '0;
      wd_q      <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(OFF_WRD)) wd_q <= reg_wdata;
      if (start) begin
        phy_q   <= reg_wdata[PHY_LSB +: FIELD_W];
        rg_q    <= reg_wdata[REG_LSB +: FIELD_W];
        wr_busy <= go_wr;
        rd_busy <= go_rd;
      end else if (done) begin
        if (rd_busy) rd_q <= rx;
        wr_busy <= 1'b0;
        rd_busy <= 1'b0;
      end
      if (reg_addr == ADDR_W'(OFF_CMD))
        reg_rdata <= {1'b0, wr_busy, rd_busy, phy_q, 3'b000, rg_q};
      else if (reg_addr == ADDR_W'(OFF_RDD))
        reg_rdata <= rd_q;
      else if (reg_addr == ADDR_W'(OFF_WRD))
        reg_rdata <= wd_q;
      else
        reg_rdata <= '0;
    end
  end

  // R6
  one_busy_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({wr_busy, rd_busy}));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_sel) |=> $stable(phy_q) && $stable(rg_q));
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MDC_HALF = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              start, start_wr, busy, run, done, rise_stb, fall_stb;
  logic [DATA_W-1:0] wd_q, rx;

  mdio_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .done(done), .rx(rx), .reg_rdata(reg_rdata),
    .start(start), .start_wr(start_wr), .busy(busy), .wd_q(wd_q)
  );

  mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) i_mdc (
    .clk(clk), .rst(rst), .run(run), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame i_frame (
    .clk(clk), .rst(rst), .start(start), .is_wr(start_wr),
    .phy(reg_wdata[PHY_LSB +: FIELD_W]), .rg(reg_wdata[REG_LSB +: FIELD_W]),
    .wdata(wd_q), .mdio_i(mdio_i), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rx(rx)
  );

  // R6
  busy_run_chk: assert property (@(posedge clk) disable iff (rst) busy |-> run);
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (rst) done |=> !busy && !mdc);
endmodule

// File: tb/test_mdio_ctrl.sv
module test_mdio_ctrl;
  localparam int HALF = 10;
  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int errors = 0, checks = 0, cap_n = 0;
  logic [63:0] cap_val = '0, cap_oe = '0;
  logic [15:0] resp = '0;
  realtime t_prev = 0, period = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_ctrl #(.ADDR_W(8), .MDC_HALF(HALF)) i_mdio_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  always @(posedge mdc) begin
    if (cap_n < 64) begin
      cap_val[63-cap_n] = mdio_o;
      cap_oe[63-cap_n]  = mdio_oe;
    end
    if (cap_n > 0) period = $realtime - t_prev;
    t_prev = $realtime;
    cap_n = cap_n + 1;
  end

  always @(negedge mdc)
    mdio_i = (cap_n >= 48 && cap_n < 64) ? resp[63-cap_n] : 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r,
                 (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [63:0] exp_oe(input bit wr);
    exp_oe = wr ? '1 : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd_reg(8'h20, v);
      if (v[14:13] == 2'b00) break;
    end
  endtask

  task automatic txn(input bit wr, input bit both, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d, input logic [15:0] rsp);
    logic [15:0] v;
    logic [63:0] m;
    resp = rsp;
    if (wr) wr_reg(8'h28, d);
    cap_n = 0;
    wr_reg(8'h20, {1'b0, wr, (both | ~wr), p, 3'b000, r});
    rd_reg(8'h20, v);
    chk(both ? "R9 both-bits busy" : "R6 busy set", {48'h0, v},
        {48'h0, 1'b0, wr, ~wr, p, 3'b000, r});
    repeat (64) @(posedge mdc);
    repeat (HALF + 2) @(negedge clk);
    rd_reg(8'h20, v);
    chk("R6 busy clear", {62'h0, v[14:13]}, 64'h0);
    m = exp_oe(wr);
    chk(wr ? "R3 write frame" : "R4 read frame", cap_val & m, exp_frame(wr, p, r, d) & m);
    chk(wr ? "R3 oe mask" : "R4 oe release", cap_oe, m);
    chk("R7 mdc period", {32'h0, 32'(int'(period))}, {32'h0, 32'(2*HALF*20)});
    chk("R7 mdc idle", {63'h0, mdc}, 64'h0);
    if (!wr) begin
      rd_reg(8'h24, v);
      chk("R5 read data", {48'h0, v}, {48'h0, rsp});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned s;
    s = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mdc", {63'h0, mdc}, 64'h0);
    chk("R1 oe", {63'h0, mdio_oe}, 64'h0);
    rd_reg(8'h20, v); chk("R1 cmd", {48'h0, v}, 64'h0);
    rd_reg(8'h24, v); chk("R1 rdata", {48'h0, v}, 64'h0);
    rd_reg(8'h28, v); chk("R1 wdata", {48'h0, v}, 64'h0);
    // R2 write-data readback
    wr_reg(8'h28, 16'hA55A);
    rd_reg(8'h28, v); chk("R2 wdata readback", {48'h0, v}, 64'hA55A);

    // directed corners
    txn(1'b1, 1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0);
    txn(1'b0, 1'b0, 5'h00, 5'h00, 16'h0, 16'h0001);
    txn(1'b0, 1'b0, 5'h15, 5'h0A, 16'h0, 16'h8000);
    txn(1'b1, 1'b1, 5'h03, 5'h11, 16'h1234, 16'h0);

    // R9 neither bit set: nothing starts, fields unchanged
    cap_n = 0;
    wr_reg(8'h20, 16'h0105);
    repeat (100) @(negedge clk);
    chk("R9 no frame", 64'(cap_n), 64'h0);
    rd_reg(8'h20, v);
    chk("R9 fields kept", {48'h0, v}, {48'h0, 16'h0311});

    // R8 command during busy is ignored
    resp = 16'hC3A5;
    cap_n = 0;
    wr_reg(8'h20, {1'b0, 1'b0, 1'b1, 5'h07, 3'b000, 5'h02});
    repeat (300) @(negedge clk);
    wr_reg(8'h20, {1'b0, 1'b1, 1'b0, 5'h19, 3'b000, 5'h1C});
    rd_reg(8'h20, v);
    chk("R8 busy ignore", {48'h0, v}, {48'h0, 16'h2702});
    wait_idle();
    chk("R8 frame kept", cap_val & exp_oe(1'b0), exp_frame(1'b0, 5'h07, 5'h02, 16'h0) & exp_oe(1'b0));
    rd_reg(8'h24, v);
    chk("R5 read after ignore", {48'h0, v}, 64'hC3A5);

    // R8 command in the completion cycle is ignored
    wr_reg(8'h28, 16'h0F0F);
    cap_n = 0;
    wr_reg(8'h20, {1'b0, 1'b1, 1'b0, 5'h0C, 3'b000, 5'h04});
    repeat (64) @(posedge mdc);
    repeat (HALF) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h20;
    reg_wdata = {1'b0, 1'b0, 1'b1, 5'h1E, 3'b000, 5'h01};
    @(negedge clk); reg_wr = 1'b0;
    repeat (300) @(negedge clk);
    chk("R8 collide no frame", 64'(cap_n), 64'd64);
    chk("R8 collide mdc", {63'h0, mdc}, 64'h0);
    rd_reg(8'h20, v);
    chk("R8 collide fields", {48'h0, v}, {48'h0, 16'h0C04});

    // random transactions
    for (int i = 0; i < 12; i++) begin
      bit w;
      w = bit'($urandom_range(0, 1));
      txn(w, 1'b0, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule